// File: doc/BRIEF.md
# Storage Response Packet Parser

This block consumes the byte stream that a serial storage device returns after a command has been issued to it. Once armed with the number of bytes the host asked for, it frames each incoming packet as a flag byte, a length byte, a body of that many bytes and a two-byte checksum. Body bytes of data packets are forwarded on a write port together with their offset from the start of the transfer. Packets repeat until an end packet arrives. The end packet carries the completion status of the transfer.

At completion the parser reports one of four outcomes: success, soft error, hard error or failure. It also reports the residual byte count. It keeps wrapping counters of soft, hard and checksum errors. Two receiver conditions are handled separately. A line break resets the protocol and asks for reinitialisation. An overrun is flagged, and the byte that carried it is still parsed. Building and transmitting commands happens elsewhere.

Top module: `rsp_parser`

## Requirements
- R1: While idle (busy low), received bytes are ignored: no data beat, no completion, no reinitialisation request and no error counter change. After reset, busy, all pulses and all counters are zero.
- R2: Every packet is framed as a flag byte, a length byte N, N body bytes and a checksum whose low byte arrives first. For a data packet (flag 0x01), each body byte appears on dataByte with dataValid one cycle after it is received. dataAddr is the byte offset from the start of the transfer and runs on across packets.
- R3: After the checksum of a data packet, the parser expects a new header.
- R4: A packet with flag 0x02 whose first body byte is 0x40 is an end packet. Its second body byte is the status. One cycle after its last checksum byte, doneValid pulses and busy drops. doneStatus is 0 when the status is 0. It is 1 when the status is 1, and softErrCnt then increments. It is 2 when the status is above 1, and hardErrCnt then increments.
- R5: residual at completion equals reqCount minus the sum of the lengths of the completed data packets, with a floor of zero.
- R6: The expected checksum is the 16-bit end-around-carry sum of all header and body bytes. A byte at an even position from the flag byte is added in the low lane, and a byte at an odd position in the high lane. On a mismatch, cksumErrCnt increments and parsing continues unchanged.
- R7: Any other completed packet ends the transfer. doneValid pulses with doneStatus 3, reinitReq pulses, and the parser goes idle.
- R8: A byte 0x04 arriving in the flag position fails the transfer at once. doneValid pulses with doneStatus 3, reinitReq pulses, and the parser goes idle.
- R9: A byte received with rxFrameErr high and rxOverrun low while busy is a line break. reinitReq pulses, the parser goes idle without a completion, and the byte is discarded.
- R10: A byte received with rxOverrun high makes overrunSeen pulse one cycle later. The byte is parsed normally.
- R11: A start pulse while busy is ignored. The transfer keeps its requested count and its data offset.
- R12: A data packet of length zero goes straight from its header to its checksum. It emits no data beat and leaves the residual unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arm a new transfer (only when idle) |
| reqCount | input | 16 | Requested byte count for the transfer |
| rxValid | input | 1 | Received byte strobe |
| rxByte | input | 8 | Received byte |
| rxFrameErr | input | 1 | Framing error flag for rxByte |
| rxOverrun | input | 1 | Overrun flag for rxByte |
| busy | output | 1 | Transfer in progress |
| dataValid | output | 1 | Data beat strobe |
| dataByte | output | 8 | Data payload byte |
| dataAddr | output | 16 | Offset of the byte in the transfer |
| doneValid | output | 1 | Completion pulse |
| doneStatus | output | 2 | 0 ok, 1 soft, 2 hard, 3 failed |
| residual | output | 16 | Bytes not transferred |
| reinitReq | output | 1 | Request to reinitialise the device link |
| overrunSeen | output | 1 | Overrun reported on the last byte |
| softErrCnt | output | 8 | Soft error count |
| hardErrCnt | output | 8 | Hard error count |
| cksumErrCnt | output | 8 | Checksum error count |

## Verification
The hardest situations to reach are the ones that arrive in the middle of a packet. One is a line break that lands between body bytes. The other is a start pulse that arrives after the first data packet of a transfer. The bench reaches both by driving the byte stream one byte at a time. It injects the error flag, or the extra start, at a chosen byte index. It then keeps sending the rest of the stream and confirms that the stream has no effect, or has the proper effect. A sweep over request sizes, packet lengths, packet counts and status codes covers the residual arithmetic, the address continuity and the error classification. A corrupted checksum is placed in selected packets.

// File: rtl/rsp_parse_pkg.sv
package rsp_parse_pkg;
  localparam logic [7:0] FLAG_DATA = 8'h01;
  localparam logic [7:0] FLAG_CMD  = 8'h02;
  localparam logic [7:0] FLAG_INIT = 8'h04;
  localparam logic [7:0] OP_END    = 8'h40;

  typedef enum logic [2:0] {S_IDLE, S_FLAG, S_CNT, S_BODY, S_CKLO, S_CKHI} state_t;
  typedef enum logic [1:0] {ST_OK = 2'd0, ST_SOFT = 2'd1, ST_HARD = 2'd2, ST_FAIL = 2'd3} status_t;
  typedef enum logic [1:0] {PK_DATA, PK_END, PK_OTHER} kind_t;

  typedef struct packed {
    logic startXfer;
    logic capFlag;
    logic capCnt;
    logic bodyByte;
    logic ckLo;
    logic ckHi;
    logic initFail;
    logic brk;
  } strobe_t;
endpackage

// File: rtl/rsp_cksum_acc.sv
module rsp_cksum_acc #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                addEn,
  input  logic                restart,
  input  logic                hiLane,
  input  logic [BYTE_W-1:0]   byteIn,
  output logic [2*BYTE_W-1:0] sum
);
  localparam int SUM_W = 2 * BYTE_W;

  logic [SUM_W-1:0] base, addend, folded;
  logic [SUM_W:0]   wide;

  always_comb begin
    base   = restart ? '0 : sum;
    addend = hiLane ? {byteIn, {BYTE_W{1'b0}}} : {{BYTE_W{1'b0}}, byteIn};
    wide   = {1'b0, base} + {1'b0, addend};
    folded = wide[SUM_W-1:0] + SUM_W'(wide[SUM_W]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)      sum <= '0;
    else if (addEn) sum <= folded;
  end
endmodule

// File: rtl/rsp_parse_ctrl.sv
module rsp_parse_ctrl
  import rsp_parse_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      rxValid,
  input  logic      isBreak,
  input  logic [7:0] rxByte,
  input  logic      bodyLast,
  input  kind_t     kind,
  output strobe_t   st,
  output logic      busy
);
  state_t state, nxt;

  always_comb begin
    st  = '0;
    nxt = state;
    if (state == S_IDLE) begin
      if (start) begin
        st.startXfer = 1'b1;
        nxt = S_FLAG;
      end
    end else if (rxValid) begin
      if (isBreak) begin
        st.brk = 1'b1;
        nxt = S_IDLE;
      end else begin
        unique case (state)
          S_FLAG: begin
            if (rxByte == FLAG_INIT) begin
              st.initFail = 1'b1;
              nxt = S_IDLE;
            end else begin
              st.capFlag = 1'b1;
              nxt = S_CNT;
            end
          end
          S_CNT: begin
            st.capCnt = 1'b1;
            nxt = (rxByte == 8'd0) ? S_CKLO : S_BODY;
          end
          S_BODY: begin
            st.bodyByte = 1'b1;
            if (bodyLast) nxt = S_CKLO;
          end
          S_CKLO: begin
            st.ckLo = 1'b1;
            nxt = S_CKHI;
          end
          S_CKHI: begin
            st.ckHi = 1'b1;
            nxt = (kind == PK_DATA) ? S_FLAG : S_IDLE;
          end
          default: nxt = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign busy = (state != S_IDLE);

  p_break_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && isBreak && state != S_IDLE) |=> state == S_IDLE);
  p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(st));
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> !st.startXfer);
  p_data_rehdr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st.ckHi && kind == PK_DATA) |=> state == S_FLAG);
endmodule

// File: rtl/rsp_parse_dp.sv
module rsp_parse_dp
  import rsp_parse_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 16,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              rxOverrun,
  input  logic [LEN_W-1:0]  reqCount,
  output logic              bodyLast,
  output kind_t             kind,
  output logic              dataValid,
  output logic [7:0]        dataByte,
  output logic [ADDR_W-1:0] dataAddr,
  output logic              doneValid,
  output status_t           doneStatus,
  output logic [LEN_W-1:0]  residual,
  output logic              reinitReq,
  output logic              overrunSeen,
  output logic [ERR_W-1:0]  softCnt,
  output logic [ERR_W-1:0]  hardCnt,
  output logic [ERR_W-1:0]  cksumCnt
);
  logic [7:0]        pktFlag, pktCnt, bodyIdx, opReg, modReg, ckLoReg;
  logic [ADDR_W-1:0] xferAddr;
  logic [LEN_W-1:0]  remaining, remNext;
  logic [15:0]       accSum;
  logic              accAdd, accHi;

  assign accAdd = st.capFlag | st.capCnt | st.bodyByte;
  assign accHi  = st.capCnt | (st.bodyByte & bodyIdx[0]);

  rsp_cksum_acc #(.BYTE_W(8)) u_acc (
    .clk    (clk),
    .rstN   (rstN),
    .addEn  (accAdd),
    .restart(st.capFlag),
    .hiLane (accHi),
    .byteIn (rxByte),
    .sum    (accSum)
  );

  assign bodyLast = (bodyIdx == pktCnt - 8'd1);

  always_comb begin
    if (pktFlag == FLAG_DATA)                        kind = PK_DATA;
    else if (pktFlag == FLAG_CMD && opReg == OP_END) kind = PK_END;
    else                                             kind = PK_OTHER;
    remNext = (remaining > LEN_W'(pktCnt)) ? remaining - LEN_W'(pktCnt) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktFlag <= '0; pktCnt <= '0; bodyIdx <= '0; opReg <= '0; modReg <= '0;
      ckLoReg <= '0; xferAddr <= '0; remaining <= '0;
      dataValid <= 1'b0; dataByte <= '0; dataAddr <= '0;
      doneValid <= 1'b0; doneStatus <= ST_OK; residual <= '0;
      reinitReq <= 1'b0; overrunSeen <= 1'b0;
      softCnt <= '0; hardCnt <= '0; cksumCnt <= '0;
    end else begin
      dataValid   <= 1'b0;
      doneValid   <= 1'b0;
      reinitReq   <= 1'b0;
      overrunSeen <= rxValid & rxOverrun;
      if (st.startXfer) begin
        xferAddr  <= '0;
        remaining <= reqCount;
      end
      if (st.capFlag) begin
        pktFlag <= rxByte;
        opReg   <= '0;
        modReg  <= '0;
        bodyIdx <= '0;
      end
      if (st.capCnt) pktCnt <= rxByte;
      if (st.bodyByte) begin
        bodyIdx <= bodyIdx + 8'd1;
        if (bodyIdx == 8'd0) opReg  <= rxByte;
        if (bodyIdx == 8'd1) modReg <= rxByte;
        if (pktFlag == FLAG_DATA) begin
          dataValid <= 1'b1;
          dataByte  <= rxByte;
          dataAddr  <= xferAddr + ADDR_W'(bodyIdx);
        end
      end
      if (st.ckLo) ckLoReg <= rxByte;
      if (st.ckHi) begin
        if ({rxByte, ckLoReg} != accSum) cksumCnt <= cksumCnt + 1'b1;
        unique case (kind)
          PK_DATA: begin
            xferAddr  <= xferAddr + ADDR_W'(pktCnt);
            remaining <= remNext;
          end
          PK_END: begin
            doneValid <= 1'b1;
            residual  <= remaining;
            if (modReg == 8'd0) doneStatus <= ST_OK;
            else if (modReg == 8'd1) begin
              doneStatus <= ST_SOFT;
              softCnt    <= softCnt + 1'b1;
            end else begin
              doneStatus <= ST_HARD;
              hardCnt    <= hardCnt + 1'b1;
            end
          end
          default: begin
            doneValid  <= 1'b1;
            doneStatus <= ST_FAIL;
            residual   <= remaining;
            reinitReq  <= 1'b1;
          end
        endcase
      end
      if (st.initFail) begin
        doneValid  <= 1'b1;
        doneStatus <= ST_FAIL;
        residual   <= remaining;
        reinitReq  <= 1'b1;
      end
      if (st.brk) reinitReq <= 1'b1;
    end
  end

  p_ck_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cksumCnt == $past(cksumCnt) || cksumCnt == $past(cksumCnt) + 1'b1));
  p_rem_mono_r5: assert property (@(posedge clk) disable iff (!rstN)
    !st.startXfer |=> remaining <= $past(remaining));
  p_hard_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneStatus == ST_HARD) |-> hardCnt == $past(hardCnt) + 1'b1);
  p_beat_not_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(dataValid && doneValid));
endmodule

// File: rtl/rsp_parser.sv
module rsp_parser
  import rsp_parse_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 16,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  reqCount,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              rxFrameErr,
  input  logic              rxOverrun,
  output logic              busy,
  output logic              dataValid,
  output logic [7:0]        dataByte,
  output logic [ADDR_W-1:0] dataAddr,
  output logic              doneValid,
  output logic [1:0]        doneStatus,
  output logic [LEN_W-1:0]  residual,
  output logic              reinitReq,
  output logic              overrunSeen,
  output logic [ERR_W-1:0]  softErrCnt,
  output logic [ERR_W-1:0]  hardErrCnt,
  output logic [ERR_W-1:0]  cksumErrCnt
);
  strobe_t st;
  kind_t   kind;
  status_t statusQ;
  logic    bodyLast;
  logic    isBreak;

  assign isBreak = rxFrameErr & ~rxOverrun;

  rsp_parse_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .rxValid (rxValid),
    .isBreak (isBreak),
    .rxByte  (rxByte),
    .bodyLast(bodyLast),
    .kind    (kind),
    .st      (st),
    .busy    (busy)
  );

  rsp_parse_dp #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .rxValid    (rxValid),
    .rxByte     (rxByte),
    .rxOverrun  (rxOverrun),
    .reqCount   (reqCount),
    .bodyLast   (bodyLast),
    .kind       (kind),
    .dataValid  (dataValid),
    .dataByte   (dataByte),
    .dataAddr   (dataAddr),
    .doneValid  (doneValid),
    .doneStatus (statusQ),
    .residual   (residual),
    .reinitReq  (reinitReq),
    .overrunSeen(overrunSeen),
    .softCnt    (softErrCnt),
    .hardCnt    (hardErrCnt),
    .cksumCnt   (cksumErrCnt)
  );

  assign doneStatus = statusQ;

  p_ovr_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxOverrun) |=> overrunSeen);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> !dataValid && !doneValid);
endmodule

// File: tb/rsp_parser_tb.sv
module rsp_parser_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [15:0] reqCount = '0;
  logic rxValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic rxFrameErr = 1'b0;
  logic rxOverrun = 1'b0;
  logic busy, dataValid, doneValid, reinitReq, overrunSeen;
  logic [7:0] dataByte, softErrCnt, hardErrCnt, cksumErrCnt;
  logic [15:0] dataAddr, residual;
  logic [1:0] doneStatus;

  always #10 clk = ~clk;

  rsp_parser u_dut (
    .clk(clk), .rstN(rstN), .start(start), .reqCount(reqCount),
    .rxValid(rxValid), .rxByte(rxByte), .rxFrameErr(rxFrameErr), .rxOverrun(rxOverrun),
    .busy(busy), .dataValid(dataValid), .dataByte(dataByte), .dataAddr(dataAddr),
    .doneValid(doneValid), .doneStatus(doneStatus), .residual(residual),
    .reinitReq(reinitReq), .overrunSeen(overrunSeen),
    .softErrCnt(softErrCnt), .hardErrCnt(hardErrCnt), .cksumErrCnt(cksumErrCnt)
  );

  int nChk = 0, nFail = 0;
  int doneEv = 0, reinitEv = 0, ovEv = 0;
  int lastStatus = 0, lastResid = 0;
  int expAddr = 0, sendAddr = 0;
  int expSoft = 0, expHard = 0, expCk = 0;
  bit dataOk = 1'b0;
  bit finished = 1'b0;
  logic [7:0] pktBuf [0:31];

  task automatic chkEq(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [15:0] ckOf(int n);
    logic [15:0] a = '0;
    logic [16:0] s;
    logic [15:0] ad;
    for (int i = 0; i < n; i++) begin
      ad = (i % 2 == 1) ? {pktBuf[i], 8'h00} : {8'h00, pktBuf[i]};
      s = {1'b0, a} + {1'b0, ad};
      a = s[15:0] + 16'(s[16]);
    end
    return a;
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      if (doneValid) begin
        doneEv++; lastStatus = doneStatus; lastResid = residual;
      end
      if (reinitReq) reinitEv++;
      if (overrunSeen) ovEv++;
      if (dataValid) begin
        if (!dataOk) chkEq("R1 unexpected data beat", 1, 0);
        else begin
          chkEq("R2 data offset", dataAddr, expAddr);
          chkEq("R2 data byte", dataByte, pat(expAddr));
        end
        expAddr++;
      end
    end
  end

  task automatic sendByte(logic [7:0] b, bit fe, bit ov);
    @(negedge clk);
    rxValid = 1'b1; rxByte = b; rxFrameErr = fe; rxOverrun = ov;
    @(negedge clk);
    rxValid = 1'b0; rxFrameErr = 1'b0; rxOverrun = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic pulseStart(int req);
    @(negedge clk);
    start = 1'b1; reqCount = 16'(req);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic sendPkt(int n, bit corrupt, int ovPos);
    logic [15:0] c;
    c = ckOf(n) ^ (corrupt ? 16'h0001 : 16'h0000);
    for (int i = 0; i < n; i++) sendByte(pktBuf[i], i == ovPos, i == ovPos);
    sendByte(c[7:0], 1'b0, 1'b0);
    sendByte(c[15:8], 1'b0, 1'b0);
  endtask

  task automatic buildData(int sz);
    pktBuf[0] = 8'h01; pktBuf[1] = 8'(sz);
    for (int i = 0; i < sz; i++) pktBuf[2 + i] = pat(sendAddr + i);
    sendAddr += sz;
  endtask

  task automatic buildEnd(logic [7:0] stat, logic [7:0] op);
    pktBuf[0] = 8'h02; pktBuf[1] = 8'd10; pktBuf[2] = op; pktBuf[3] = stat;
    for (int i = 4; i < 12; i++) pktBuf[i] = 8'(i * 5);
  endtask

  task automatic runXfer(int req, int sz, int np, logic [7:0] stat, int badPk);
    int d0, total, er, es;
    d0 = doneEv; expAddr = 0; sendAddr = 0; dataOk = 1'b1;
    pulseStart(req);
    for (int p = 0; p < np; p++) begin
      buildData(sz);
      sendPkt(2 + sz, p == badPk, -1);
      if (p == badPk) expCk++;
    end
    buildEnd(stat, 8'h40);
    sendPkt(12, 1'b0, -1);
    settle();
    dataOk = 1'b0;
    total = sz * np;
    er = (req > total) ? req - total : 0;
    if (stat == 0) es = 0;
    else if (stat == 1) begin es = 1; expSoft++; end
    else begin es = 2; expHard++; end
    chkEq("R4 one completion", doneEv, d0 + 1);
    chkEq("R4 status code", lastStatus, es);
    chkEq("R4 idle after end", busy, 0);
    chkEq("R5 residual", lastResid, er);
    chkEq("R3 beats over all packets", expAddr, total);
    chkEq("R4 soft counter", softErrCnt, expSoft & 255);
    chkEq("R4 hard counter", hardErrCnt, expHard & 255);
    chkEq("R6 checksum counter", cksumErrCnt, expCk & 255);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int reqs[4] = '{0, 5, 16, 40};
    int szs[4]  = '{1, 2, 3, 8};
    logic [7:0] stats[4] = '{8'd0, 8'd1, 8'd2, 8'h81};
    int iter, d0, r0, o0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkEq("R1 busy after reset", busy, 0);
    chkEq("R1 dataValid after reset", dataValid, 0);
    chkEq("R1 doneValid after reset", doneValid, 0);
    chkEq("R1 counters after reset", softErrCnt + hardErrCnt + cksumErrCnt, 0);
    // R1 idle stream ignored
    sendAddr = 0; buildData(3); sendPkt(5, 1'b1, -1);
    buildEnd(8'd2, 8'h40); sendPkt(12, 1'b0, -1);
    settle();
    chkEq("R1 no completion when idle", doneEv, 0);
    chkEq("R1 no reinit when idle", reinitEv, 0);
    chkEq("R1 counters unchanged when idle", softErrCnt + hardErrCnt + cksumErrCnt, 0);
    chkEq("R1 still idle", busy, 0);

    // sweep R2..R6
    iter = 0;
    foreach (reqs[a]) foreach (szs[b]) for (int np = 0; np < 4; np++) foreach (stats[c]) begin
      runXfer(reqs[a], szs[b], np, stats[c], (np > 0 && iter % 5 == 0) ? iter % np : 99);
      iter++;
    end

    // R12 zero-length data packets
    runXfer(10, 0, 2, 8'd0, 99);
    chkEq("R12 residual unchanged", lastResid, 10);

    // R7 unknown flag
    d0 = doneEv; r0 = reinitEv;
    pulseStart(9);
    pktBuf[0] = 8'h07; pktBuf[1] = 8'd2; pktBuf[2] = 8'h40; pktBuf[3] = 8'h00;
    sendPkt(4, 1'b0, -1); settle();
    chkEq("R7 completion on unknown flag", doneEv, d0 + 1);
    chkEq("R7 failed status", lastStatus, 3);
    chkEq("R7 reinit requested", reinitEv, r0 + 1);
    chkEq("R7 idle", busy, 0);
    // R7 command flag with wrong opcode
    d0 = doneEv; r0 = reinitEv;
    pulseStart(9);
    buildEnd(8'd0, 8'h41); sendPkt(12, 1'b0, -1); settle();
    chkEq("R7 wrong opcode completes", doneEv, d0 + 1);
    chkEq("R7 wrong opcode failed", lastStatus, 3);
    chkEq("R7 wrong opcode reinit", reinitEv, r0 + 1);

    // R8 init byte at flag position after one data packet
    d0 = doneEv; r0 = reinitEv; expAddr = 0; sendAddr = 0; dataOk = 1'b1;
    pulseStart(7);
    buildData(2); sendPkt(4, 1'b0, -1);
    sendByte(8'h04, 1'b0, 1'b0); settle();
    chkEq("R8 failed completion", doneEv, d0 + 1);
    chkEq("R8 failed status", lastStatus, 3);
    chkEq("R8 residual at failure", lastResid, 5);
    chkEq("R8 reinit", reinitEv, r0 + 1);
    chkEq("R8 idle", busy, 0);
    dataOk = 1'b0;

    // R9 line break mid-body
    d0 = doneEv; r0 = reinitEv; expAddr = 0; dataOk = 1'b1;
    pulseStart(20);
    sendByte(8'h01, 1'b0, 1'b0); sendByte(8'd4, 1'b0, 1'b0);
    sendByte(pat(0), 1'b0, 1'b0); sendByte(pat(1), 1'b0, 1'b0);
    sendByte(pat(2), 1'b1, 1'b0);
    settle();
    dataOk = 1'b0;
    chkEq("R9 reinit on break", reinitEv, r0 + 1);
    chkEq("R9 no completion on break", doneEv, d0);
    chkEq("R9 idle after break", busy, 0);
    sendByte(pat(3), 1'b0, 1'b0); sendByte(8'h00, 1'b0, 1'b0); sendByte(8'h00, 1'b0, 1'b0);
    settle();
    chkEq("R9 later bytes discarded", expAddr, 2);

    // R10 overrun byte still parsed
    d0 = doneEv; o0 = ovEv; expAddr = 0; sendAddr = 0; dataOk = 1'b1;
    pulseStart(8);
    buildData(3); sendPkt(5, 1'b0, 2);
    buildEnd(8'd0, 8'h40); sendPkt(12, 1'b0, -1); settle();
    dataOk = 1'b0;
    chkEq("R10 overrun reported", ovEv, o0 + 1);
    chkEq("R10 byte kept", expAddr, 3);
    chkEq("R10 transfer ok", lastStatus, 0);
    chkEq("R10 residual", lastResid, 5);
    chkEq("R10 checksum still good", cksumErrCnt, expCk & 255);

    // R11 start while busy ignored
    d0 = doneEv; expAddr = 0; sendAddr = 0; dataOk = 1'b1;
    pulseStart(12);
    buildData(4); sendPkt(6, 1'b0, -1);
    pulseStart(100);
    buildData(4); sendPkt(6, 1'b0, -1);
    buildEnd(8'd0, 8'h40); sendPkt(12, 1'b0, -1); settle();
    dataOk = 1'b0;
    chkEq("R11 single completion", doneEv, d0 + 1);
    chkEq("R11 offset continued", expAddr, 8);
    chkEq("R11 original request kept", lastResid, 4);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule